// File: doc/BRIEF.md
# Multi-Mode Preset Up/Down Counter

This block is a 24-bit up/down position counter driven by single-cycle count pulses from an upstream quadrature decoder. A preset value input serves as both the load source and the boundary for two of the four wrap behaviours. A two-bit mode selects how the count behaves at its limits. In free mode the count wraps at the 24-bit ends. In range-limit mode it stops at the preset going up and at zero going down. In one-shot (non-recycle) mode counting halts after a 24-bit overflow or underflow. In modulo mode the count cycles between zero and the preset.

Sticky carry and borrow flags record boundary crossings. Their exclusive-OR gives a 25th count bit that widens the readable range. A direction flag reports the sense of the last accepted pulse. The preset can be loaded by an explicit strobe. It can also be loaded by the already-qualified index condition, provided the index-load option is selected.

The behaviour is a four-state machine:
- **RUN** is the normal counting state.
- **HELD_TOP** is entered when an up step is refused at the preset in range-limit mode. It is left to RUN by a down step.
- **HELD_BOT** is entered when a down step is refused at zero in range-limit mode. It is left to RUN by an up step.
- **HALT** is entered on a 24-bit overflow or underflow in one-shot mode.

Any preset load moves every state to RUN.

Top module: `updn_preset_counter`

## Requirements
- R1: After reset, count is 0, carry and borrow are 0, ext_bit is 0 and dir_up is 1.
- R2: Pulses are taken only while cnt_en is 1. With cnt_en at 0, neither the count nor dir_up changes. All outputs are registered and change on the clock edge that samples the input.
- R3: If up_pulse and dn_pulse are both 1 in the same cycle, they cancel and the count does not change.
- R4: With count_mode 0 (free), the count wraps in both directions. An up step from 0xFFFFFF gives 0 and sets carry. A down step from 0 gives 0xFFFFFF and sets borrow.
- R5: Carry and borrow stay set until flag_clr is 1. If a flag is set and cleared in the same cycle, the set wins. ext_bit always equals carry XOR borrow.
- R6: With count_mode 1 (range limit), an up step is refused while the count equals preset_val, and a down step is refused at 0. After a refusal, steps in that direction stay refused until one step in the opposite direction is taken.
- R7: With count_mode 2 (one-shot), an up step from 0xFFFFFF wraps to 0 and sets carry. A down step from 0 wraps to 0xFFFFFF and sets borrow. After either, every step is ignored until a preset load.
- R8: With count_mode 3 (modulo), an up step at count == preset_val gives 0 and sets carry. A down step at 0 gives preset_val and sets borrow.
- R9: preset_load copies preset_val into the count on the next edge and takes priority over any pulse.
- R10: While index_load_en and index_active are both 1, the count is loaded with preset_val on every edge. With index_load_en at 0, index_active has no effect.
- R11: dir_up becomes 1 after an accepted lone up pulse and 0 after an accepted lone down pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count input enable |
| up_pulse | input | 1 | One-cycle up-count request |
| dn_pulse | input | 1 | One-cycle down-count request |
| count_mode | input | 2 | 0 free, 1 range limit, 2 one-shot, 3 modulo |
| preset_val | input | 24 | Preset value, load source and boundary |
| preset_load | input | 1 | Load preset into count |
| index_active | input | 1 | Qualified index condition |
| index_load_en | input | 1 | Select load-on-index behaviour |
| flag_clr | input | 1 | Clear carry and borrow |
| count | output | 24 | Current count |
| carry | output | 1 | Sticky overflow flag |
| borrow | output | 1 | Sticky underflow flag |
| ext_bit | output | 1 | 25th count bit, carry XOR borrow |
| dir_up | output | 1 | Direction of last accepted pulse |

## Verification
Each mode is driven with single up steps, single down steps and direction reversals placed right at its boundaries: the 24-bit ends for free and one-shot modes, and the preset and zero for range-limit and modulo modes. These patterns separate wrapping, freezing, halting and modulo reload from one another. Simultaneous up and down pulses and disabled pulses show that steps are gated before the mode logic. Loads by strobe and by index, issued together with pulses, show load priority. The same index condition with the option cleared shows that the index is ignored. A flag clear issued in the same cycle as a new overflow tells set-wins apart from clear-wins.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    typedef enum logic [1:0] {
        MODE_FREE    = 2'd0,
        MODE_LIMIT   = 2'd1,
        MODE_ONESHOT = 2'd2,
        MODE_MODULO  = 2'd3
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HELD_TOP = 2'd1,
        ST_HELD_BOT = 2'd2,
        ST_HALT     = 2'd3
    } cnt_state_e;

    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_INC  = 3'd1,
        ACT_DEC  = 3'd2,
        ACT_LOAD = 3'd3,
        ACT_ZERO = 3'd4,
        ACT_TOP  = 3'd5
    } cnt_act_e;

endpackage

// File: rtl/updn_step_gate.sv
module updn_step_gate (
    input  logic cnt_en,
    input  logic up_pulse,
    input  logic dn_pulse,
    output logic step_up,
    output logic step_dn
);
    // a lone, enabled pulse becomes a step; coincident pulses cancel
    always_comb begin
        step_up = cnt_en && up_pulse && !dn_pulse;
        step_dn = cnt_en && dn_pulse && !up_pulse;
    end
endmodule

// File: rtl/updn_bound_cmp.sv
module updn_bound_cmp #(
    parameter int W = 24
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] preset_val,
    output logic         at_max,
    output logic         at_zero,
    output logic         at_preset
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_comb begin
        at_max    = (count == CNT_MAX);
        at_zero   = (count == '0);
        at_preset = (count == preset_val);
    end
endmodule

// File: rtl/updn_mode_fsm.sv
module updn_mode_fsm
    import updn_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cnt_mode_e  mode,
    input  logic       step_up,
    input  logic       step_dn,
    input  logic       load_req,
    input  logic       at_max,
    input  logic       at_zero,
    input  logic       at_preset,
    output cnt_act_e   act,
    output logic       set_carry,
    output logic       set_borrow
);
    cnt_state_e cur, nxt;

    // response of a running counter to one step, per mode
    cnt_act_e   run_act;
    cnt_state_e run_nxt;
    logic       run_c, run_b;

    always_comb begin
        run_act = ACT_HOLD;
        run_nxt = ST_RUN;
        run_c   = 1'b0;
        run_b   = 1'b0;
        if (step_up) begin
            unique case (mode)
                MODE_FREE: begin
                    run_act = ACT_INC;
                    run_c   = at_max;
                end
                MODE_LIMIT: begin
                    if (at_preset) begin
                        run_nxt = ST_HELD_TOP;
                    end else begin
                        run_act = ACT_INC;
                        run_c   = at_max;
                    end
                end
                MODE_ONESHOT: begin
                    run_act = ACT_INC;
                    run_c   = at_max;
                    if (at_max) run_nxt = ST_HALT;
                end
                MODE_MODULO: begin
                    if (at_preset) begin
                        run_act = ACT_ZERO;
                        run_c   = 1'b1;
                    end else begin
                        run_act = ACT_INC;
                        run_c   = at_max;
                    end
                end
            endcase
        end else if (step_dn) begin
            unique case (mode)
                MODE_FREE: begin
                    run_act = ACT_DEC;
                    run_b   = at_zero;
                end
                MODE_LIMIT: begin
                    if (at_zero) begin
                        run_nxt = ST_HELD_BOT;
                    end else begin
                        run_act = ACT_DEC;
                    end
                end
                MODE_ONESHOT: begin
                    run_act = ACT_DEC;
                    run_b   = at_zero;
                    if (at_zero) run_nxt = ST_HALT;
                end
                MODE_MODULO: begin
                    if (at_zero) begin
                        run_act = ACT_TOP;
                        run_b   = 1'b1;
                    end else begin
                        run_act = ACT_DEC;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= ST_RUN;
        else        cur <= nxt;
    end

    // next state and actions
    always_comb begin
        nxt        = cur;
        act        = ACT_HOLD;
        set_carry  = 1'b0;
        set_borrow = 1'b0;
        if (load_req) begin
            nxt = ST_RUN;
            act = ACT_LOAD;
        end else begin
            unique case (cur)
                ST_RUN: begin
                    if (step_up || step_dn) begin
                        nxt = run_nxt; act = run_act;
                        set_carry = run_c; set_borrow = run_b;
                    end
                end
                ST_HELD_TOP: begin
                    if (step_dn) begin
                        nxt = run_nxt; act = run_act;
                        set_carry = run_c; set_borrow = run_b;
                    end
                end
                ST_HELD_BOT: begin
                    if (step_up) begin
                        nxt = run_nxt; act = run_act;
                        set_carry = run_c; set_borrow = run_b;
                    end
                end
                ST_HALT: begin
                    nxt = ST_HALT;
                end
            endcase
        end
    end

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_HALT && !load_req) |=> (cur == ST_HALT));

    // R6
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LIMIT && step_up && at_preset && !load_req && cur != ST_HALT)
        |=> (cur == ST_HELD_TOP));
endmodule

// File: rtl/updn_count_dp.sv
module updn_count_dp
    import updn_cnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_act_e     act,
    input  logic         set_carry,
    input  logic         set_borrow,
    input  logic         flag_clr,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] count,
    output logic         carry,
    output logic         borrow,
    output logic         dir_up
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (act)
                ACT_INC:  count <= count + 1'b1;
                ACT_DEC:  count <= count - 1'b1;
                ACT_LOAD: count <= preset_val;
                ACT_ZERO: count <= '0;
                ACT_TOP:  count <= preset_val;
                default:  count <= count;
            endcase
        end
    end

    // sticky flags: a new set outranks a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else begin
            if (set_carry)     carry <= 1'b1;
            else if (flag_clr) carry <= 1'b0;
            if (set_borrow)    borrow <= 1'b1;
            else if (flag_clr) borrow <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dir_up <= 1'b1;
        else if (step_up) dir_up <= 1'b1;
        else if (step_dn) dir_up <= 1'b0;
    end

    // R5
    carry_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !flag_clr) |=> carry);

    // R5
    borrow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (borrow && !flag_clr) |=> borrow);
endmodule

// File: rtl/updn_preset_counter.sv
module updn_preset_counter
    import updn_cnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             up_pulse,
    input  logic             dn_pulse,
    input  logic [1:0]       count_mode,
    input  logic [CNT_W-1:0] preset_val,
    input  logic             preset_load,
    input  logic             index_active,
    input  logic             index_load_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             carry,
    output logic             borrow,
    output logic             ext_bit,
    output logic             dir_up
);
    logic      step_up, step_dn;
    logic      at_max, at_zero, at_preset;
    logic      load_req;
    logic      set_carry, set_borrow;
    cnt_act_e  act;
    cnt_mode_e mode;

    assign mode     = cnt_mode_e'(count_mode);
    assign load_req = preset_load || (index_load_en && index_active);
    assign ext_bit  = carry ^ borrow;

    updn_step_gate u_gate (
        .cnt_en   (cnt_en),
        .up_pulse (up_pulse),
        .dn_pulse (dn_pulse),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    updn_bound_cmp #(.W(CNT_W)) u_cmp (
        .count      (count),
        .preset_val (preset_val),
        .at_max     (at_max),
        .at_zero    (at_zero),
        .at_preset  (at_preset)
    );

    updn_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .load_req   (load_req),
        .at_max     (at_max),
        .at_zero    (at_zero),
        .at_preset  (at_preset),
        .act        (act),
        .set_carry  (set_carry),
        .set_borrow (set_borrow)
    );

    updn_count_dp #(.W(CNT_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .set_carry  (set_carry),
        .set_borrow (set_borrow),
        .flag_clr   (flag_clr),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .preset_val (preset_val),
        .count      (count),
        .carry      (carry),
        .borrow     (borrow),
        .dir_up     (dir_up)
    );

    // R3
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_pulse && dn_pulse && !load_req) |=> $stable(count));

    // R2
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !load_req) |=> $stable(count));

    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset_load |=> (count == $past(preset_val)));

    // R11
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && up_pulse && !dn_pulse) |=> dir_up);
endmodule

// File: tb/updn_preset_counter_bench.sv
module updn_preset_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, up_pulse = 1'b0, dn_pulse = 1'b0;
    logic [1:0]  count_mode = 2'd0;
    logic [23:0] preset_val = '0;
    logic        preset_load = 1'b0, index_active = 1'b0, index_load_en = 1'b0, flag_clr = 1'b0;
    logic [23:0] count;
    logic        carry, borrow, ext_bit, dir_up;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    updn_preset_counter u_updn_preset_counter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .up_pulse(up_pulse),
        .dn_pulse(dn_pulse), .count_mode(count_mode), .preset_val(preset_val),
        .preset_load(preset_load), .index_active(index_active),
        .index_load_en(index_load_en), .flag_clr(flag_clr), .count(count),
        .carry(carry), .borrow(borrow), .ext_bit(ext_bit), .dir_up(dir_up)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one clock edge; inputs change and outputs are sampled 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic step(input logic u, input logic d);
        up_pulse = u; dn_pulse = d;
        tick();
        up_pulse = 1'b0; dn_pulse = 1'b0;
    endtask

    task automatic load(input logic [23:0] v);
        preset_val = v; preset_load = 1'b1;
        tick();
        preset_load = 1'b0;
    endtask

    task automatic clr_flags();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 carry", carry, 0);
        chk("R1 borrow", borrow, 0);
        chk("R1 ext_bit", ext_bit, 0);
        chk("R1 dir_up", dir_up, 1);
    endtask

    task automatic t_enable();
        cnt_en = 1'b0;
        step(1, 0); step(1, 0); step(1, 0);
        chk("R2 count unchanged when disabled", count, 0);
        step(0, 1);
        chk("R2 dir unchanged when disabled", dir_up, 1);
        cnt_en = 1'b1;
        step(1, 0);
        chk("R2 count after enable", count, 1);
    endtask

    task automatic t_cancel();
        step(1, 1);
        chk("R3 coincident pulses cancel", count, 1);
        step(1, 1);
        chk("R3 coincident pulses cancel again", count, 1);
    endtask

    task automatic t_free();
        count_mode = 2'd0;
        load(24'hFFFFFE);
        chk("R9 load value", count, 32'hFFFFFE);
        step(1, 0);
        chk("R4 up to max", count, 32'hFFFFFF);
        chk("R4 no carry yet", carry, 0);
        step(1, 0);
        chk("R4 wrap to zero", count, 0);
        chk("R4 carry set", carry, 1);
        chk("R5 ext_bit from carry", ext_bit, 1);
        chk("R11 dir up", dir_up, 1);
        step(1, 0);
        chk("R5 carry sticky", carry, 1);
        clr_flags();
        chk("R5 carry cleared", carry, 0);
        load(24'h0);
        step(0, 1);
        chk("R4 down wrap to max", count, 32'hFFFFFF);
        chk("R4 borrow set", borrow, 1);
        chk("R11 dir down", dir_up, 0);
        // overflow in the same cycle as a clear: set wins for carry, borrow clears
        flag_clr = 1'b1;
        step(1, 0);
        flag_clr = 1'b0;
        chk("R5 set beats clear", carry, 1);
        chk("R5 borrow cleared", borrow, 0);
        step(0, 1);
        chk("R5 both flags ext_bit", ext_bit, 0);
        clr_flags();
    endtask

    task automatic t_limit();
        count_mode = 2'd1;
        load(24'd5);
        step(1, 0);
        chk("R6 frozen at preset", count, 5);
        step(1, 0);
        chk("R6 still frozen", count, 5);
        step(0, 1);
        chk("R6 resumes on reversal", count, 4);
        step(1, 0);
        chk("R6 back to preset", count, 5);
        step(1, 0);
        chk("R6 frozen again", count, 5);
        load(24'd1);
        preset_val = 24'd5;
        step(0, 1);
        chk("R6 down to zero", count, 0);
        step(0, 1);
        chk("R6 frozen at zero", count, 0);
        chk("R6 no borrow", borrow, 0);
        step(1, 0);
        chk("R6 resumes up from zero", count, 1);
    endtask

    task automatic t_oneshot();
        count_mode = 2'd2;
        load(24'hFFFFFF);
        step(1, 0);
        chk("R7 overflow wraps", count, 0);
        chk("R7 carry set", carry, 1);
        step(1, 0);
        chk("R7 halted up", count, 0);
        step(0, 1);
        chk("R7 halted down", count, 0);
        load(24'd7);
        step(1, 0);
        chk("R7 counting after load", count, 8);
        clr_flags();
        load(24'd0);
        step(0, 1);
        chk("R7 underflow wraps", count, 32'hFFFFFF);
        chk("R7 borrow set", borrow, 1);
        step(0, 1);
        chk("R7 halted after underflow", count, 32'hFFFFFF);
        clr_flags();
    endtask

    task automatic t_modulo();
        count_mode = 2'd3;
        load(24'd3);
        step(1, 0);
        chk("R8 preset to zero", count, 0);
        chk("R8 carry on modulo wrap", carry, 1);
        clr_flags();
        step(0, 1);
        chk("R8 zero to preset", count, 3);
        chk("R8 borrow on modulo wrap", borrow, 1);
        step(0, 1);
        chk("R8 normal down", count, 2);
        clr_flags();
    endtask

    task automatic t_load_index();
        count_mode = 2'd0;
        load(24'd10);
        preset_val = 24'h123456; preset_load = 1'b1;
        step(1, 0);
        preset_load = 1'b0;
        chk("R9 load beats pulse", count, 32'h123456);
        load(24'd20);
        preset_val = 24'h00ABCD;
        index_active = 1'b1; index_load_en = 1'b0;
        step(1, 0);
        chk("R10 index ignored when option off", count, 21);
        index_load_en = 1'b1;
        step(1, 0);
        chk("R10 index loads preset", count, 32'h00ABCD);
        step(1, 0);
        chk("R10 index holds preset", count, 32'h00ABCD);
        index_active = 1'b0;
        step(1, 0);
        chk("R10 counting after index", count, 32'h00ABCE);
        index_load_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_enable();
        t_cancel();
        t_free();
        t_limit();
        t_oneshot();
        t_modulo();
        t_load_index();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule